// File: doc/BRIEF.md
# Fixed-Head Disk Controller Register File

This block is the register set that a host processor sees when it drives a fixed-head disk controller. A small word-addressed bus reaches eight 16-bit registers: command/status, disk address, error status, word count, current memory address, maintenance, look-ahead and data buffer. Word writes and byte writes are both supported, and read data comes back one clock after the access.

Writing the command/status register with GO set starts an operation, but only if the controller is idle (DONE set). The block then sends a one-cycle start strobe, with its function code, to a separate transfer engine. A write with the abort bit set sends a one-cycle abort strobe. The engine reports back with a done pulse, error pulses, a set of error-register bits and data-buffer loads. The block keeps the summary error bit and the interrupt request current.

The look-ahead register gives a rough view of where the disk is turning. Each read of it moves its sector bits forward by one. A disk-address write checks the platter select field at once against the configured number of platters.

Top module: `dskc_regs`

## Requirements
- R1: After synchronous reset the command/status register reads 0x0080 (DONE, bit 7, set), every other register reads 0x0000, and irq, eng_start and eng_abort are low.
- R2: bus_addr[3:1] selects the register: 0 look-ahead, 1 disk address, 2 error status, 3 command/status, 4 word count, 5 current address, 6 maintenance, 7 data buffer. A read (bus_sel=1, bus_wr=0) puts that register's value on bus_rdata one cycle later, and bus_rdata holds until the next read.
- R3: Writes to the look-ahead, error status and data buffer registers change nothing.
- R4: With bus_byte=1, bus_wdata[7:0] replaces the high byte when bus_addr[0]=1 and the low byte when bus_addr[0]=0, and the other byte is kept. Word writes replace all 16 bits.
- R5: A disk-address write keeps bits 12:0 and first clears the nonexistent-disk flag (command/status bit 11). If bits 12:11 are greater than or equal to PLATTERS, the flag is set again. If they are below PLATTERS, the look-ahead register is loaded with the new address.
- R6: A look-ahead read returns its bits 12:0, with bit 15 set when command/status bit 11 or error-register bit 5 (overflow) is set. After the read, its bits 5:0 step up by one modulo 64 and bits 12:6 stay the same.
- R7: Command/status writes store only inhibit (bit 9), interrupt enable (bit 6), memory extension (bits 5:4), maintenance (bit 3) and function (bits 2:1). Abort (bit 8) and GO (bit 0) always read as 0. The current address keeps bit 0 at 0, and the maintenance register keeps only bits 15:6.
- R8: A command/status write with bit 8 set forces DONE and pulses eng_abort for one cycle in the following cycle.
- R9: A write with GO set while DONE is set, counting a DONE forced by abort in the same write, pulses eng_start for one cycle with eng_func equal to bits 2:1 of the write. The same write clears DONE, bits 14:10, the error register and irq. GO while DONE is clear does nothing.
- R10: Command/status bit 15 reads 1 exactly when any of bits 14:10 is set or the error register is nonzero.
- R11: irq rises when DONE rises while interrupt enable is set, and when interrupt enable is written to 1 while DONE is already set and enable was 0. Writing enable to 0 drops irq.
- R12: An eng_done pulse sets DONE. eng_errs[4:0] is ORed into command/status bits 14:10, eng_er_set is ORed into the error register, and eng_db_we loads eng_db into the data buffer.
- R13: eng_daddr shows the disk address, eng_maddr shows {memory extension, current address}, eng_wcount shows the word count, and eng_inhibit shows command/status bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_byte | input | 1 | Byte write |
| bus_addr | input | 4 | Bits 3:1 register, bit 0 byte lane |
| bus_wdata | input | 16 | Write data (byte on bits 7:0) |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle start strobe |
| eng_func | output | 2 | Function code with eng_start |
| eng_abort | output | 1 | One-cycle abort strobe |
| eng_daddr | output | 13 | Disk address |
| eng_maddr | output | 18 | Memory address with extension |
| eng_wcount | output | 16 | Word count |
| eng_inhibit | output | 1 | Address-increment inhibit |
| eng_done | input | 1 | Operation finished pulse |
| eng_errs | input | 5 | Status error bits 14:10 to set |
| eng_er_set | input | 16 | Error register bits to set |
| eng_db_we | input | 1 | Data buffer load |
| eng_db | input | 16 | Data buffer value |

## Verification
Every register update, strobe and irq change is due at the first clock edge after the access or engine pulse is sampled. Read data is due on bus_rdata at that same edge, built from the register values held before the edge. The bench drives inputs on the falling edge, steps a behavioural model at each rising edge and compares every output at the next falling edge. Every result is therefore checked in exactly the cycle it is due. Look-ahead rotation is checked through repeated reads across the modulo-64 wrap.

// File: rtl/dskc_pkg.sv
package dskc_pkg;
  localparam int DATA_W = 16;
  localparam int DA_W   = 13;
  localparam int ROT_W  = 6;
  localparam int ERR_N  = 5;
  localparam int MEX_W  = 2;

  typedef enum logic [2:0] {
    REG_LA = 3'd0, REG_DA = 3'd1, REG_ER = 3'd2, REG_CS = 3'd3,
    REG_WC = 3'd4, REG_CA = 3'd5, REG_MN = 3'd6, REG_DB = 3'd7
  } reg_sel_e;

  localparam int CS_SUM  = 15;
  localparam int CS_ERLO = 10;
  localparam int CS_NED  = 11;
  localparam int CS_INH  = 9;
  localparam int CS_ABO  = 8;
  localparam int CS_DONE = 7;
  localparam int CS_IE   = 6;
  localparam int CS_MEXL = 4;
  localparam int CS_MNT  = 3;
  localparam int CS_FNL  = 1;
  localparam int CS_GO   = 0;
  localparam int ER_OVF  = 5;
  localparam int LA_BAD  = 15;

  localparam logic [DATA_W-1:0] CA_KEEP = 16'hFFFE;
  localparam logic [DATA_W-1:0] MN_KEEP = 16'hFFC0;

  function automatic logic [DATA_W-1:0] merge_bytes(
      input logic [DATA_W-1:0] old_v, input logic [DATA_W-1:0] new_v,
      input logic byte_wr, input logic hi_lane);
    if (!byte_wr) return new_v;
    if (hi_lane) return {new_v[7:0], old_v[7:0]};
    return {old_v[15:8], new_v[7:0]};
  endfunction
endpackage

// File: rtl/dskc_addr.sv
module dskc_addr
  import dskc_pkg::*;
#(
  parameter int PLATTERS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            da_we,
  input  logic [DA_W-1:0] da_wdata,
  input  logic            la_rd,
  output logic [DA_W-1:0] da_q,
  output logic [DA_W-1:0] la_q,
  output logic            unit_bad
);
  logic [1:0] unit_sel;
  assign unit_sel = da_wdata[DA_W-1 -: 2];
  assign unit_bad = (int'(unit_sel) >= PLATTERS);

  always_ff @(posedge clk) begin
    if (rst) begin
      da_q <= '0;
      la_q <= '0;
    end else if (da_we) begin
      da_q <= da_wdata;
      if (!unit_bad) la_q <= da_wdata;
    end else if (la_rd) begin
      la_q[ROT_W-1:0] <= la_q[ROT_W-1:0] + 1'b1;
    end
  end
endmodule

// File: rtl/dskc_data.sv
module dskc_data
  import dskc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wc_we,
  input  logic              ca_we,
  input  logic              mn_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              start_now,
  input  logic [DATA_W-1:0] eng_er_set,
  input  logic              eng_db_we,
  input  logic [DATA_W-1:0] eng_db,
  output logic [DATA_W-1:0] er_q,
  output logic [DATA_W-1:0] wc_q,
  output logic [DATA_W-1:0] ca_q,
  output logic [DATA_W-1:0] mn_q,
  output logic [DATA_W-1:0] db_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      er_q <= '0;
      wc_q <= '0;
      ca_q <= '0;
      mn_q <= '0;
      db_q <= '0;
    end else begin
      if (start_now) er_q <= '0;
      else er_q <= er_q | eng_er_set;
      if (wc_we) wc_q <= wdata;
      if (ca_we) ca_q <= wdata & CA_KEEP;
      if (mn_we) mn_q <= wdata & MN_KEEP;
      if (eng_db_we) db_q <= eng_db;
    end
  end
endmodule

// File: rtl/dskc_csr.sv
module dskc_csr
  import dskc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_we,
  input  logic              wr_inh,
  input  logic              wr_abo,
  input  logic              wr_ie,
  input  logic [MEX_W-1:0]  wr_mex,
  input  logic              wr_mnt,
  input  logic [1:0]        wr_func,
  input  logic              wr_go,
  input  logic              da_we,
  input  logic              unit_bad,
  input  logic              er_nz,
  input  logic              eng_done,
  input  logic [ERR_N-1:0]  eng_errs,
  output logic [DATA_W-1:0] cs_value,
  output logic              done_q,
  output logic              ie_q,
  output logic              inh_q,
  output logic [MEX_W-1:0]  mex_q,
  output logic              start_now,
  output logic              irq,
  output logic              eng_start,
  output logic [1:0]        eng_func,
  output logic              eng_abort
);
  logic [ERR_N-1:0] errs_q;
  logic             mnt_q;
  logic [1:0]       func_q;
  logic             done_after;

  assign done_after = done_q | wr_abo;
  assign start_now  = cs_we & wr_go & done_after;

  assign cs_value = {(|errs_q) | er_nz, errs_q, inh_q, 1'b0, done_q, ie_q,
                     mex_q, mnt_q, func_q, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      errs_q    <= '0;
      inh_q     <= 1'b0;
      ie_q      <= 1'b0;
      mex_q     <= '0;
      mnt_q     <= 1'b0;
      func_q    <= '0;
      done_q    <= 1'b1;
      irq       <= 1'b0;
      eng_start <= 1'b0;
      eng_func  <= '0;
      eng_abort <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      eng_abort <= 1'b0;
      errs_q    <= errs_q | eng_errs;
      if (eng_done) begin
        done_q <= 1'b1;
        if (!done_q && ie_q) irq <= 1'b1;
      end
      if (da_we) errs_q[CS_NED-CS_ERLO] <= unit_bad;
      if (cs_we) begin
        if (wr_abo) begin
          done_q    <= 1'b1;
          eng_abort <= 1'b1;
          if (!done_q && ie_q) irq <= 1'b1;
        end
        if (!wr_ie) irq <= 1'b0;
        else if (done_after && !ie_q) irq <= 1'b1;
        inh_q  <= wr_inh;
        ie_q   <= wr_ie;
        mex_q  <= wr_mex;
        mnt_q  <= wr_mnt;
        func_q <= wr_func;
        if (start_now) begin
          eng_start <= 1'b1;
          eng_func  <= wr_func;
          errs_q    <= '0;
          done_q    <= 1'b0;
          irq       <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dskc_regs.sv
module dskc_regs
  import dskc_pkg::*;
#(
  parameter int PLATTERS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_byte,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        eng_start,
  output logic [1:0]  eng_func,
  output logic        eng_abort,
  output logic [12:0] eng_daddr,
  output logic [17:0] eng_maddr,
  output logic [15:0] eng_wcount,
  output logic        eng_inhibit,
  input  logic        eng_done,
  input  logic [4:0]  eng_errs,
  input  logic [15:0] eng_er_set,
  input  logic        eng_db_we,
  input  logic [15:0] eng_db
);
  reg_sel_e          sel;
  logic              wr_en, rd_en;
  logic              da_we, cs_we, wc_we, ca_we, mn_we, la_rd;
  logic [DATA_W-1:0] old_val, merged, rd_val, cs_value;
  logic [DA_W-1:0]   da_q, la_q;
  logic [DATA_W-1:0] er_q, wc_q, ca_q, mn_q, db_q;
  logic              unit_bad, start_now, cs_done, cs_ie, cs_inh;
  logic [MEX_W-1:0]  cs_mex;
  logic              la_flag;

  assign sel   = reg_sel_e'(bus_addr[3:1]);
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;
  assign da_we = wr_en & (sel == REG_DA);
  assign cs_we = wr_en & (sel == REG_CS);
  assign wc_we = wr_en & (sel == REG_WC);
  assign ca_we = wr_en & (sel == REG_CA);
  assign mn_we = wr_en & (sel == REG_MN);
  assign la_rd = rd_en & (sel == REG_LA);

  always_comb begin
    unique case (sel)
      REG_DA:  old_val = {{(DATA_W-DA_W){1'b0}}, da_q};
      REG_CS:  old_val = cs_value;
      REG_WC:  old_val = wc_q;
      REG_CA:  old_val = ca_q;
      REG_MN:  old_val = mn_q;
      default: old_val = '0;
    endcase
  end

  assign merged  = merge_bytes(old_val, bus_wdata, bus_byte, bus_addr[0]);
  assign la_flag = cs_value[CS_NED] | er_q[ER_OVF];

  always_comb begin
    unique case (sel)
      REG_LA:  rd_val = {la_flag, {(DATA_W-DA_W-1){1'b0}}, la_q};
      REG_DA:  rd_val = {{(DATA_W-DA_W){1'b0}}, da_q};
      REG_ER:  rd_val = er_q;
      REG_CS:  rd_val = cs_value;
      REG_WC:  rd_val = wc_q;
      REG_CA:  rd_val = ca_q;
      REG_MN:  rd_val = mn_q;
      default: rd_val = db_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_val;
  end

  dskc_addr #(.PLATTERS(PLATTERS)) u_addr (
    .clk(clk), .rst(rst), .da_we(da_we), .da_wdata(merged[DA_W-1:0]),
    .la_rd(la_rd), .da_q(da_q), .la_q(la_q), .unit_bad(unit_bad)
  );

  dskc_data u_data (
    .clk(clk), .rst(rst), .wc_we(wc_we), .ca_we(ca_we), .mn_we(mn_we),
    .wdata(merged), .start_now(start_now), .eng_er_set(eng_er_set),
    .eng_db_we(eng_db_we), .eng_db(eng_db), .er_q(er_q), .wc_q(wc_q),
    .ca_q(ca_q), .mn_q(mn_q), .db_q(db_q)
  );

  dskc_csr u_csr (
    .clk(clk), .rst(rst), .cs_we(cs_we),
    .wr_inh(merged[CS_INH]), .wr_abo(merged[CS_ABO]), .wr_ie(merged[CS_IE]),
    .wr_mex(merged[CS_MEXL +: MEX_W]), .wr_mnt(merged[CS_MNT]),
    .wr_func(merged[CS_FNL +: 2]), .wr_go(merged[CS_GO]),
    .da_we(da_we), .unit_bad(unit_bad), .er_nz(|er_q),
    .eng_done(eng_done), .eng_errs(eng_errs), .cs_value(cs_value),
    .done_q(cs_done), .ie_q(cs_ie), .inh_q(cs_inh), .mex_q(cs_mex),
    .start_now(start_now), .irq(irq), .eng_start(eng_start),
    .eng_func(eng_func), .eng_abort(eng_abort)
  );

  assign eng_daddr   = da_q;
  assign eng_maddr   = {cs_mex, ca_q};
  assign eng_wcount  = wc_q;
  assign eng_inhibit = cs_inh;
endmodule

// File: rtl/dskc_regs_chk.sv
module dskc_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       eng_start,
  input logic       eng_abort,
  input logic       done,
  input logic       ie,
  input logic       la_rd,
  input logic [5:0] la_low
);
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> (!done && !irq)); // R9
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start); // R9
  AST_IRQ_NEEDS_IE_DONE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ie && done)); // R11
  AST_ABORT_DONE: assert property (@(posedge clk) disable iff (rst)
    (eng_abort && !eng_start) |-> done); // R8
  AST_LA_ROTATE: assert property (@(posedge clk) disable iff (rst)
    la_rd |=> (la_low == $past(la_low) + 6'd1)); // R6
endmodule

bind dskc_regs dskc_regs_chk u_chk (
  .clk(clk), .rst(rst), .irq(irq), .eng_start(eng_start),
  .eng_abort(eng_abort), .done(cs_done), .ie(cs_ie), .la_rd(la_rd),
  .la_low(la_q[5:0])
);

// File: tb/dskc_regs_tb_top.sv
module dskc_regs_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0, bus_byte = 0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq, eng_start, eng_abort, eng_inhibit;
  logic [1:0] eng_func;
  logic [12:0] eng_daddr;
  logic [17:0] eng_maddr;
  logic [15:0] eng_wcount;
  logic eng_done = 0, eng_db_we = 0;
  logic [4:0] eng_errs = '0;
  logic [15:0] eng_er_set = '0, eng_db = '0;

  int n_checks = 0, n_errs = 0, cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dskc_regs #(.PLATTERS(2)) dut_i (.*);

  // behavioural model state
  int m_la, m_da, m_er, m_wc, m_ca, m_mn, m_db, m_rdata, m_errs, m_mex, m_func;
  bit m_done, m_ie, m_inh, m_maint, m_irq, m_start, m_abort;
  int m_sfunc;

  function automatic int m_cs();
    int v;
    v = (m_errs << 10) | (m_inh << 9) | (m_done << 7) | (m_ie << 6) |
        (m_mex << 4) | (m_maint << 3) | (m_func << 1);
    if (m_errs != 0 || m_er != 0) v |= 32'h8000;
    return v;
  endfunction

  function automatic int m_read(input int off);
    case (off)
      0: return (m_la & 16'h1FFF) | ((((m_errs >> 1) & 1) != 0 || (m_er & 32'h20) != 0) ? 32'h8000 : 0);
      1: return m_da;
      2: return m_er;
      3: return m_cs();
      4: return m_wc;
      5: return m_ca;
      6: return m_mn;
      default: return m_db;
    endcase
  endfunction

  function automatic int mrg(input int old, input int d);
    if (!bus_byte) return d & 16'hFFFF;
    if (bus_addr[0]) return ((d & 8'hFF) << 8) | (old & 8'hFF);
    return (old & 16'hFF00) | (d & 8'hFF);
  endfunction

  always @(posedge clk) begin
    int off, d, unit;
    bit oldie;
    if (rst) begin
      m_la = 0; m_da = 0; m_er = 0; m_wc = 0; m_ca = 0; m_mn = 0; m_db = 0;
      m_rdata = 0; m_errs = 0; m_mex = 0; m_func = 0; m_done = 1; m_ie = 0;
      m_inh = 0; m_maint = 0; m_irq = 0; m_start = 0; m_abort = 0; m_sfunc = 0;
    end else begin
      m_start = 0; m_abort = 0;
      off = int'(bus_addr[3:1]);
      m_errs |= int'(eng_errs);
      if (eng_done) begin
        if (!m_done && m_ie) m_irq = 1;
        m_done = 1;
      end
      if (bus_sel && !bus_wr) begin
        m_rdata = m_read(off);
        if (off == 0) m_la = (m_la & ~63) | ((m_la + 1) & 63);
      end
      if (bus_sel && bus_wr) begin
        case (off)
          1: begin
            m_da = mrg(m_da, int'(bus_wdata)) & 16'h1FFF;
            unit = (m_da >> 11) & 3;
            m_errs &= ~2;
            if (unit >= 2) m_errs |= 2; else m_la = m_da;
          end
          3: begin
            d = mrg(m_cs(), int'(bus_wdata));
            oldie = m_ie;
            if (d[8]) begin
              if (!m_done && oldie) m_irq = 1;
              m_done = 1; m_abort = 1;
            end
            if (!d[6]) m_irq = 0;
            else if (m_done && !oldie) m_irq = 1;
            m_inh = d[9]; m_ie = d[6]; m_mex = (d >> 4) & 3;
            m_maint = d[3]; m_func = (d >> 1) & 3;
            if (m_done && d[0]) begin
              m_start = 1; m_sfunc = m_func; m_errs = 0; m_er = 0;
              m_done = 0; m_irq = 0;
            end
          end
          4: m_wc = mrg(m_wc, int'(bus_wdata));
          5: m_ca = mrg(m_ca, int'(bus_wdata)) & 16'hFFFE;
          6: m_mn = mrg(m_mn, int'(bus_wdata)) & 16'hFFC0;
          default: ;
        endcase
      end
      if (!m_start) m_er |= int'(eng_er_set);
      if (eng_db_we) m_db = int'(eng_db);
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      chk("rdata", int'(bus_rdata), m_rdata);
      chk("irq", int'(irq), int'(m_irq));
      chk("eng_start", int'(eng_start), int'(m_start));
      if (m_start) chk("eng_func", int'(eng_func), m_sfunc);
      chk("eng_abort", int'(eng_abort), int'(m_abort));
      chk("eng_daddr (R13)", int'(eng_daddr), m_da);
      chk("eng_maddr (R13)", int'(eng_maddr), (m_mex << 16) | m_ca);
      chk("eng_wcount (R13)", int'(eng_wcount), m_wc);
      chk("eng_inhibit (R13)", int'(eng_inhibit), int'(m_inh));
    end
  end

  task automatic wr(input int off, input int d, input bit byt = 0, input bit hi = 0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_byte = byt;
    bus_addr = {off[2:0], hi}; bus_wdata = d[15:0];
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_byte = 0;
  endtask

  task automatic rd(input int off);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = {off[2:0], 1'b0};
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic eng(input bit dn, input int errs, input int er, input bit dbwe, input int db);
    @(negedge clk);
    eng_done = dn; eng_errs = errs[4:0]; eng_er_set = er[15:0];
    eng_db_we = dbwe; eng_db = db[15:0];
    @(negedge clk);
    eng_done = 0; eng_errs = '0; eng_er_set = '0; eng_db_we = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    for (int i = 0; i < 8; i++) rd(i);
    cur_req = "R2";
    wr(4, 16'h1234); wr(5, 16'h5678); rd(4); rd(5); rd(6);
    cur_req = "R7";
    wr(6, 16'hFFFF); rd(6); wr(5, 16'h0FFF); rd(5);
    wr(3, 16'h037E); rd(3); wr(3, 16'h0000); rd(3);
    cur_req = "R3";
    wr(0, 16'hFFFF); wr(2, 16'hFFFF); wr(7, 16'hFFFF); rd(0); rd(2); rd(7);
    cur_req = "R4";
    wr(4, 16'h00AB, 1, 1); rd(4); wr(4, 16'h77CD, 1, 0); rd(4);
    wr(3, 16'h0002, 1, 1); rd(3); wr(3, 16'h0000); rd(3);
    cur_req = "R5";
    wr(1, 16'h0805); rd(1); rd(0);
    wr(1, 16'h1805); rd(3); rd(0); rd(1);
    wr(1, 16'hFFFF); rd(1); rd(3);
    wr(1, 16'h003E); rd(3); rd(0);
    cur_req = "R6";
    for (int i = 0; i < 70; i++) rd(0);
    cur_req = "R10";
    eng(0, 0, 16'h0020, 0, 0); rd(2); rd(3); rd(0);
    eng(0, 5'b10000, 0, 0, 0); rd(3);
    cur_req = "R9";
    wr(3, 16'h0045); rd(3); rd(2);
    wr(3, 16'h0043); rd(3);
    cur_req = "R12";
    eng(1, 5'b00001, 16'h8000, 1, 16'h1357); rd(3); rd(2); rd(7);
    cur_req = "R11";
    wr(3, 16'h0000); rd(3); wr(3, 16'h0040); rd(3); wr(3, 16'h0040); rd(3);
    cur_req = "R8";
    wr(3, 16'h0003); rd(3); wr(3, 16'h0100); rd(3);
    wr(3, 16'h0047); wr(3, 16'h0140); rd(3);
    wr(3, 16'h0105); rd(3); wr(3, 16'h0100); rd(3);
    cur_req = "R13";
    wr(3, 16'h0230); wr(5, 16'h4444); wr(4, 16'h0009); wr(1, 16'h0123); rd(3);
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(negedge clk);
    n_errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule